// File: doc/BRIEF.md
# DDR Memory Power-Up Sequencer

This block sits on the controller side of a double-data-rate memory interface and brings the attached device from power-on to a usable state. Once reset is released it keeps the clock enable low for a programmable count of stable-clock cycles, then raises it and drives no-operation commands for a short settle time. After that it issues a fixed initialization script: a precharge of all banks, an extended mode write that turns the delay-locked loop on, a mode write that resets that loop, a second precharge of all banks, a programmable number of auto-refresh commands, and a final mode write that releases the loop reset.

Every command is held on the bus for one clock. Between commands the bus carries no-operation with the bank and address lines at zero. Each command kind has its own minimum spacing, given as a cycle-count parameter. A ready flag rises once the final mode write has had its cycle time and the lock window that started at the loop reset has run out. Normal traffic and periodic refresh belong to other blocks; they may start once the flag is high.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset and for the first STABLE_CYC rising edges after reset release, the clock enable is low and the bus carries no-operation (select low, row, column and write strobes high) with bank and address lines zero. The clock enable is high after edge number STABLE_CYC.
- R2: Once high, the clock enable never returns low until the next reset.
- R3: The first command, a precharge of all banks, is issued on edge STABLE_CYC + T_CKE. The cycles in between carry no-operation.
- R4: Commands come in this order: all-bank precharge, extended mode write, mode write with loop reset, all-bank precharge, REF_COUNT auto-refreshes, mode write without loop reset.
- R5: Strobe encodings as (select, row, column, write), active low: no-operation 0111, precharge 0010 with address bit 10 high for all banks, auto-refresh 0001, mode write 0000.
- R6: The extended mode write uses bank value 01 and an all-zero address, so address bit 0 is low and the loop is enabled.
- R7: Both mode writes use bank value 00, address bits 6..4 = CAS_LAT, bit 3 = BURST_TYPE, bits 2..0 = BURST_CODE. Bit 8 is 1 in the first mode write and 0 in the last. All other address bits are 0.
- R8: Each command lasts exactly one cycle. The next command follows T_RP edges after a precharge, T_MRD edges after either mode write, and T_RFC edges after a refresh. All cycles in between carry no-operation with bank and address zero.
- R9: Exactly REF_COUNT auto-refresh commands are issued.
- R10: The ready flag rises on the edge max(last mode write + T_MRD, loop-reset mode write + DLL_LOCK). It then stays high, and only no-operation follows.
- R11: When DLL_LOCK is shorter than the remaining script, the ready flag is set by the final mode write spacing instead of the lock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_o | output | 1 | Memory clock enable |
| sel_n_o | output | 1 | Active-low chip select |
| row_n_o | output | 1 | Active-low row strobe |
| col_n_o | output | 1 | Active-low column strobe |
| wen_n_o | output | 1 | Active-low write enable |
| bank_o | output | BA_W | Bank address lines |
| maddr_o | output | ADDR_W | Memory address lines |
| ready_o | output | 1 | Initialization complete |

## Verification
Every output is registered, so a command scheduled for edge k is visible from just after edge k. The bench samples all outputs at each falling edge and tags each sample with the count of rising edges since reset release. It rebuilds the expected schedule on its own from the parameters. The first command is due at STABLE_CYC + T_CKE. Each later one is due one gap after its predecessor, with the gap set by the kind of the predecessor. The ready flag is due at the larger of the two completion edges. Every sampled cycle is compared against that schedule. Spot checks are placed on the cycle just before and the cycle of each transition. Two instances with different lock windows cover both outcomes of the maximum.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    K_PALL    = 3'd0,
    K_EXTMODE = 3'd1,
    K_MODE_RS = 3'd2,
    K_REFRESH = 3'd3,
    K_MODE_GO = 3'd4
  } step_kind_e;

  typedef struct packed {
    logic sel_n;
    logic row_n;
    logic col_n;
    logic wen_n;
  } strobes_t;

  localparam strobes_t STB_NOP  = '{sel_n: 1'b0, row_n: 1'b1, col_n: 1'b1, wen_n: 1'b1};
  localparam strobes_t STB_PRE  = '{sel_n: 1'b0, row_n: 1'b0, col_n: 1'b1, wen_n: 1'b0};
  localparam strobes_t STB_REF  = '{sel_n: 1'b0, row_n: 1'b0, col_n: 1'b0, wen_n: 1'b1};
  localparam strobes_t STB_MODE = '{sel_n: 1'b0, row_n: 1'b0, col_n: 1'b0, wen_n: 1'b0};

  // Script position to command kind; refreshes fill the slots after the second precharge.
  function automatic step_kind_e kind_of(input int idx, input int nref);
    if (idx == 0 || idx == 3)       return K_PALL;
    else if (idx == 1)              return K_EXTMODE;
    else if (idx == 2)              return K_MODE_RS;
    else if (idx < 4 + nref)        return K_REFRESH;
    else                            return K_MODE_GO;
  endfunction

  function automatic strobes_t strobes_of(input step_kind_e k);
    case (k)
      K_PALL:    return STB_PRE;
      K_REFRESH: return STB_REF;
      default:   return STB_MODE;
    endcase
  endfunction

  // Spacing in cycles from a command of kind k to the next event.
  function automatic int gap_of(input step_kind_e k, input int t_rp,
                                input int t_mrd, input int t_rfc);
    case (k)
      K_PALL:    return t_rp;
      K_REFRESH: return t_rfc;
      default:   return t_mrd;
    endcase
  endfunction

  // Operating mode word: latency, burst type, burst length code, loop reset bit.
  function automatic logic [15:0] mode_word(input int cl, input logic bt,
                                            input logic [2:0] bl, input logic dll_rs);
    logic [15:0] w;
    w      = '0;
    w[6:4] = 3'(cl);
    w[3]   = bt;
    w[2:0] = bl;
    w[8]   = dll_rs;
    return w;
  endfunction

endpackage

// File: rtl/ddr_init_countdown.sv
module ddr_init_countdown #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  // Loading N makes expired_o true when the N-th following edge is evaluated.
  // The count rests at 1 once reached; 0 means idle and never expires.
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == CNT_W'(1));

  // R8: once armed the counter never wraps through zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i) |=> (cnt_q != '0));

  // R8: an expired counter stays expired until reloaded
  a_r8_hold_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
#(
  parameter int         STEP_W     = 3,
  parameter int         CNT_W      = 8,
  parameter int         ADDR_W     = 13,
  parameter int         BA_W       = 2,
  parameter int         REF_COUNT  = 2,
  parameter int         T_RP       = 3,
  parameter int         T_MRD      = 2,
  parameter int         T_RFC      = 14,
  parameter int         CAS_LAT    = 3,
  parameter bit         BURST_TYPE = 1'b0,
  parameter logic [2:0] BURST_CODE = 3'b010
) (
  input  logic [STEP_W-1:0] step_i,
  output step_kind_e        kind_o,
  output strobes_t          strobes_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  gap_o
);
  always_comb begin
    kind_o    = kind_of(int'(step_i), REF_COUNT);
    strobes_o = strobes_of(kind_o);
    gap_o     = CNT_W'(gap_of(kind_o, T_RP, T_MRD, T_RFC));
    bank_o    = '0;
    addr_o    = '0;
    case (kind_o)
      K_PALL:    addr_o[10] = 1'b1;
      K_EXTMODE: bank_o     = BA_W'(1);
      K_MODE_RS: addr_o     = ADDR_W'(mode_word(CAS_LAT, BURST_TYPE, BURST_CODE, 1'b1));
      K_MODE_GO: addr_o     = ADDR_W'(mode_word(CAS_LAT, BURST_TYPE, BURST_CODE, 1'b0));
      default:   addr_o     = '0;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         STABLE_CYC = 40000,
  parameter int         T_CKE      = 2,
  parameter int         T_RP       = 3,
  parameter int         T_MRD      = 2,
  parameter int         T_RFC      = 14,
  parameter int         DLL_LOCK   = 200,
  parameter int         REF_COUNT  = 2,
  parameter int         CAS_LAT    = 3,
  parameter bit         BURST_TYPE = 1'b0,
  parameter logic [2:0] BURST_CODE = 3'b010,
  parameter int         ADDR_W     = 13,
  parameter int         BA_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              clk_en_o,
  output logic              sel_n_o,
  output logic              row_n_o,
  output logic              col_n_o,
  output logic              wen_n_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic              ready_o
);
  localparam int N_STEPS = 5 + REF_COUNT;
  localparam int LAST    = N_STEPS - 1;
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam int MAX_A   = (STABLE_CYC > DLL_LOCK) ? STABLE_CYC : DLL_LOCK;
  localparam int MAX_B   = (T_RFC > T_CKE) ? T_RFC : T_CKE;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);

  typedef enum logic [1:0] {PH_STABLE, PH_SCRIPT, PH_TAIL, PH_READY} phase_e;

  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic              cke_q, ready_q;
  strobes_t          stb_q;
  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] addr_q;

  // named internal events
  step_kind_e        rom_kind;
  strobes_t          rom_stb;
  logic [BA_W-1:0]   rom_bank;
  logic [ADDR_W-1:0] rom_addr;
  logic [CNT_W-1:0]  rom_gap;
  logic              gap_exp, lock_exp;
  logic              issue_w, gap_load_w, lock_load_w, finish_w;
  logic [CNT_W-1:0]  gap_val_w;

  ddr_init_step_rom #(
    .STEP_W(STEP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .REF_COUNT(REF_COUNT), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .CAS_LAT(CAS_LAT), .BURST_TYPE(BURST_TYPE), .BURST_CODE(BURST_CODE)
  ) u_rom (
    .step_i(step_q), .kind_o(rom_kind), .strobes_o(rom_stb),
    .bank_o(rom_bank), .addr_o(rom_addr), .gap_o(rom_gap)
  );

  ddr_init_countdown #(.CNT_W(CNT_W), .RST_VAL(STABLE_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load_w), .load_val_i(gap_val_w),
    .expired_o(gap_exp)
  );

  ddr_init_countdown #(.CNT_W(CNT_W), .RST_VAL(0)) u_lock (
    .clk(clk), .rst_n(rst_n), .load_i(lock_load_w), .load_val_i(CNT_W'(DLL_LOCK)),
    .expired_o(lock_exp)
  );

  always_comb begin
    issue_w     = (phase_q == PH_SCRIPT) && gap_exp;
    gap_load_w  = ((phase_q == PH_STABLE) && gap_exp) || issue_w;
    gap_val_w   = (phase_q == PH_STABLE) ? CNT_W'(T_CKE) : rom_gap;
    lock_load_w = issue_w && (rom_kind == K_MODE_RS);
    finish_w    = (phase_q == PH_TAIL) && gap_exp && lock_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_STABLE;
      step_q  <= '0;
      cke_q   <= 1'b0;
      ready_q <= 1'b0;
      stb_q   <= STB_NOP;
      bank_q  <= '0;
      addr_q  <= '0;
    end else begin
      stb_q  <= STB_NOP;
      bank_q <= '0;
      addr_q <= '0;
      case (phase_q)
        PH_STABLE: if (gap_exp) begin
          cke_q   <= 1'b1;
          phase_q <= PH_SCRIPT;
        end
        PH_SCRIPT: if (issue_w) begin
          stb_q  <= rom_stb;
          bank_q <= rom_bank;
          addr_q <= rom_addr;
          if (step_q == STEP_W'(LAST)) phase_q <= PH_TAIL;
          else                         step_q  <= step_q + STEP_W'(1);
        end
        PH_TAIL: if (finish_w) begin
          ready_q <= 1'b1;
          phase_q <= PH_READY;
        end
        default: phase_q <= PH_READY;
      endcase
    end
  end

  assign clk_en_o = cke_q;
  assign sel_n_o  = stb_q.sel_n;
  assign row_n_o  = stb_q.row_n;
  assign col_n_o  = stb_q.col_n;
  assign wen_n_o  = stb_q.wen_n;
  assign bank_o   = bank_q;
  assign maddr_o  = addr_q;
  assign ready_o  = ready_q;

  // R1: while the clock enable is low only an all-zero no-operation is driven
  a_r1_quiet_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> (stb_q == STB_NOP && bank_o == '0 && maddr_o == '0));

  // R2: clock enable never drops after rising
  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |=> clk_en_o);

  // R8: a command on the bus was released by an expired spacing counter
  a_r8_cmd_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q != STB_NOP) |-> ($past(gap_exp) && clk_en_o));

  // R8: a command never occupies two consecutive cycles unless spacing is one
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q != STB_NOP && !$past(gap_exp)) |-> 1'b0);

  // R7: mode writes only target bank value 0 or 1
  a_r7_mode_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q == STB_MODE) |-> (bank_o <= BA_W'(1)));

  // R10: ready only after the lock window ran out, stays high, bus stays quiet
  a_r10_ready_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> lock_exp);
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (stb_q == STB_NOP));
endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int MAXC = 300;
  localparam int RUNC = 280;

  // main instance parameters
  localparam int A_S = 20, A_C = 4, A_RP = 3, A_MRD = 2, A_RFC = 14, A_DLL = 200, A_NREF = 2;
  localparam int A_CL = 3;
  localparam bit A_BT = 1'b0;
  localparam logic [2:0] A_BL = 3'b010;
  // short-lock instance parameters
  localparam int B_S = 5, B_C = 1, B_RP = 3, B_MRD = 2, B_RFC = 14, B_DLL = 10, B_NREF = 3;
  localparam int B_CL = 3;
  localparam bit B_BT = 1'b1;
  localparam logic [2:0] B_BL = 3'b011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic a_cke, a_sel, a_row, a_col, a_wen, a_rdy;
  logic [1:0] a_ba;
  logic [12:0] a_ad;
  logic b_cke, b_sel, b_row, b_col, b_wen, b_rdy;
  logic [1:0] b_ba;
  logic [12:0] b_ad;

  ddr_init_seq #(.STABLE_CYC(A_S), .T_CKE(A_C), .T_RP(A_RP), .T_MRD(A_MRD), .T_RFC(A_RFC),
    .DLL_LOCK(A_DLL), .REF_COUNT(A_NREF), .CAS_LAT(A_CL), .BURST_TYPE(A_BT), .BURST_CODE(A_BL))
  u_ddr_init_seq (.clk(clk), .rst_n(rst_n), .clk_en_o(a_cke), .sel_n_o(a_sel), .row_n_o(a_row),
    .col_n_o(a_col), .wen_n_o(a_wen), .bank_o(a_ba), .maddr_o(a_ad), .ready_o(a_rdy));

  ddr_init_seq #(.STABLE_CYC(B_S), .T_CKE(B_C), .T_RP(B_RP), .T_MRD(B_MRD), .T_RFC(B_RFC),
    .DLL_LOCK(B_DLL), .REF_COUNT(B_NREF), .CAS_LAT(B_CL), .BURST_TYPE(B_BT), .BURST_CODE(B_BL))
  u_ddr_init_seq_short (.clk(clk), .rst_n(rst_n), .clk_en_o(b_cke), .sel_n_o(b_sel),
    .row_n_o(b_row), .col_n_o(b_col), .wen_n_o(b_wen), .bank_o(b_ba), .maddr_o(b_ad),
    .ready_o(b_rdy));

  // sample layout: [20] clock enable, [19] ready, [18:15] strobes, [14:13] bank, [12:0] address
  logic [20:0] tr_a [0:MAXC];
  logic [20:0] tr_b [0:MAXC];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (cyc <= MAXC) begin
    tr_a[cyc] <= {a_cke, a_rdy, a_sel, a_row, a_col, a_wen, a_ba, a_ad};
    tr_b[cyc] <= {b_cke, b_rdy, b_sel, b_row, b_col, b_wen, b_ba, b_ad};
  end

  localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010, P_REF = 4'b0001, P_MODE = 4'b0000;

  task automatic chk(input string tag, input string what, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, k, act, exp);
    end
  endtask

  function automatic logic [20:0] get(input bit which_b, input int k);
    return which_b ? tr_b[k] : tr_a[k];
  endfunction

  // bench-side command word: {strobes, bank, address}
  function automatic logic [18:0] cmd_word(input int kind, input int cl, input bit bt,
                                           input logic [2:0] bl);
    logic [12:0] m;
    m = {4'b0, (kind == 2), 1'b0, 3'(cl), bt, bl};
    case (kind)
      0: return {P_PRE, 2'b00, 13'h0400};
      1: return {P_MODE, 2'b01, 13'h0000};
      3: return {P_REF, 2'b00, 13'h0000};
      default: return {P_MODE, 2'b00, m};
    endcase
  endfunction

  // Full cycle-by-cycle comparison against a schedule rebuilt from the parameters (R4, R8)
  task automatic check_trace(input bit wb, input int s, input int c, input int trp,
                             input int tmrd, input int trfc, input int dll, input int nref,
                             input int cl, input bit bt, input logic [2:0] bl);
    int edge_at [0:15];
    int kind_at [0:15];
    int t, e2, dn, n;
    n = 5 + nref;
    t = s + c;
    e2 = 0;
    for (int i = 0; i < n; i++) begin
      int kd;
      kd = (i == 0 || i == 3) ? 0 : (i == 1) ? 1 : (i == 2) ? 2 : (i < 4 + nref) ? 3 : 4;
      kind_at[i] = kd;
      edge_at[i] = t;
      if (kd == 2) e2 = t;
      t += (kd == 0) ? trp : (kd == 3) ? trfc : tmrd;
    end
    dn = (t > e2 + dll) ? t : e2 + dll;
    for (int k = 0; k <= RUNC; k++) begin
      logic [20:0] smp;
      logic [18:0] ew;
      bit is_cmd;
      smp = get(wb, k);
      ew = {P_NOP, 15'h0};
      is_cmd = 1'b0;
      for (int i = 0; i < n; i++)
        if (edge_at[i] == k) begin ew = cmd_word(kind_at[i], cl, bt, bl); is_cmd = 1'b1; end
      chk((k < s) ? "R1" : "R2", "clock enable", k, 32'(smp[20]), 32'(k >= s && k > 0));
      chk("R10", "ready", k, 32'(smp[19]), 32'(k >= dn));
      chk(is_cmd ? "R4" : "R8", "bus word", k, 32'(smp[18:0]), 32'(ew));
    end
  endtask

  task automatic t_reset_state;
    chk("R1", "reset clock enable", 0, 32'(tr_a[0][20]), 32'd0);
    chk("R1", "reset bus", 0, 32'(tr_a[0][18:0]), 32'({P_NOP, 15'h0}));
    chk("R10", "reset ready", 0, 32'(tr_a[0][19]), 32'd0);
  endtask

  task automatic t_cke_rise;
    chk("R1", "enable before count", A_S - 1, 32'(tr_a[A_S-1][20]), 32'd0);
    chk("R2", "enable at count", A_S, 32'(tr_a[A_S][20]), 32'd1);
    chk("R2", "enable late", RUNC, 32'(tr_a[RUNC][20]), 32'd1);
  endtask

  localparam int A_E0 = A_S + A_C;
  localparam int A_E1 = A_E0 + A_RP;
  localparam int A_E2 = A_E1 + A_MRD;
  localparam int A_EL = A_E2 + A_MRD + A_RP + A_NREF * A_RFC;
  localparam int A_DN = (A_EL + A_MRD > A_E2 + A_DLL) ? A_EL + A_MRD : A_E2 + A_DLL;
  localparam int B_E2 = B_S + B_C + B_RP + B_MRD;
  localparam int B_EL = B_E2 + B_MRD + B_RP + B_NREF * B_RFC;
  localparam int B_DN = (B_EL + B_MRD > B_E2 + B_DLL) ? B_EL + B_MRD : B_E2 + B_DLL;

  task automatic t_first_command;
    chk("R3", "nop before first", A_E0 - 1, 32'(tr_a[A_E0-1][18:15]), 32'(P_NOP));
    chk("R3", "first is precharge", A_E0, 32'(tr_a[A_E0][18:15]), 32'(P_PRE));
    chk("R5", "precharge all bit", A_E0, 32'(tr_a[A_E0][10]), 32'd1);
  endtask

  task automatic t_mode_words;
    chk("R6", "ext mode bank", A_E1, 32'(tr_a[A_E1][14:13]), 32'd1);
    chk("R6", "ext mode address", A_E1, 32'(tr_a[A_E1][12:0]), 32'd0);
    chk("R5", "ext mode strobes", A_E1, 32'(tr_a[A_E1][18:15]), 32'(P_MODE));
    chk("R7", "loop reset word", A_E2, 32'(tr_a[A_E2][14:0]), 32'h0132);
    chk("R7", "final word", A_EL, 32'(tr_a[A_EL][14:0]), 32'h0032);
    chk("R7", "short final word", B_EL, 32'(tr_b[B_EL][14:0]), 32'h003B);
  endtask

  task automatic t_refresh_count;
    int na, nb;
    na = 0; nb = 0;
    for (int k = 0; k <= RUNC; k++) begin
      if (tr_a[k][18:15] == P_REF) na++;
      if (tr_b[k][18:15] == P_REF) nb++;
    end
    chk("R9", "refreshes main", RUNC, 32'(na), 32'(A_NREF));
    chk("R9", "refreshes short", RUNC, 32'(nb), 32'(B_NREF));
    chk("R5", "refresh encoding", A_E2 + A_MRD + A_RP, 32'(tr_a[A_E2+A_MRD+A_RP][18:15]), 32'(P_REF));
  endtask

  task automatic t_ready;
    chk("R10", "ready before lock", A_DN - 1, 32'(tr_a[A_DN-1][19]), 32'd0);
    chk("R10", "ready at lock", A_DN, 32'(tr_a[A_DN][19]), 32'd1);
    chk("R11", "short ready early", B_DN - 1, 32'(tr_b[B_DN-1][19]), 32'd0);
    chk("R11", "short ready at spacing", B_DN, 32'(tr_b[B_DN][19]), 32'd1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait (cyc >= RUNC + 1);
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    t_cke_rise();
    t_first_command();
    t_mode_words();
    t_refresh_count();
    t_ready();
    check_trace(1'b0, A_S, A_C, A_RP, A_MRD, A_RFC, A_DLL, A_NREF, A_CL, A_BT, A_BL);
    check_trace(1'b1, B_S, B_C, B_RP, B_MRD, B_RFC, B_DLL, B_NREF, B_CL, B_BT, B_BL);
    finished = 1'b1;
    finish_run();
  end
endmodule